// File: doc/BRIEF.md
# Cascaded Interval Timer Snapshot Reader

This block takes one coherent 32-bit elapsed-time sample from an external timer peripheral. The peripheral holds two chained 16-bit down counters behind a byte-wide register bus. When a start pulse arrives, the reader writes a freeze command to the peripheral's shared control register, so that both counters are captured at the same instant. It then reads the upper-half counter and the lower-half counter, two bytes each.

The four bytes are masked to eight bits and paired into two 16-bit counts. Each count is then turned from a down-count into an up-count. The upper half is negated. The lower half is subtracted from one, because that counter wraps at one instead of zero. A lower word of zero on the first pass is known to be unreliable, so the whole freeze-and-read sequence runs a second time and its values are final. The 32-bit result comes out with a one-cycle done strobe, and a busy flag covers the whole operation.

Top module: `tmr_snapshot_reader`

## Requirements
- R1: After a synchronous reset, `busy` is 0, `done` is 0 and `result` is 0.
- R2: Every pass begins with a single write of the freeze command (default 0xDC) to the control address (default 0x43). No read comes before it in that pass.
- R3: After the freeze write, a pass issues exactly four reads in this order: two from the upper counter address (default 0x42), then two from the lower counter address (default 0x41). The first read of each counter returns its least significant byte.
- R4: Only bits [7:0] of each returned read word are used. The upper bits of `bus_rdata` have no effect on `result`.
- R5: `result[31:16]` equals 0 minus the frozen upper count, modulo 2^16.
- R6: `result[15:0]` equals 1 minus the frozen lower count, modulo 2^16.
- R7: If the lower word computed on the first pass is zero, the full sequence (freeze plus four reads) runs exactly once more. The second pass's values are presented even if its lower word is also zero. A nonzero first pass gives exactly one pass.
- R8: `done` is high for exactly one cycle, with `result` valid in that cycle. `busy` is high from the cycle after start is sampled until `done` rises, and is low while `done` is high.
- R9: A start pulse that arrives while `busy` is high is ignored. It causes no extra bus traffic and no extra `done`.
- R10: `result` holds its value between one `done` and the next.
- R11: A synchronous reset during a read returns the block to idle with the retry record cleared. A following read with a zero first-pass lower word again gets its one retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request for a new sample |
| busy | output | 1 | High while a sample is in progress |
| done | output | 1 | One-cycle strobe marking a fresh result |
| result | output | 32 | Up-counting elapsed value |
| bus_addr | output | ADDR_W | Register bus address |
| bus_wdata | output | 8 | Register bus write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe; data returns one cycle later |
| bus_rdata | input | RDATA_W | Read data, valid the cycle after `bus_rd` |

## Verification
The bench uses the default parameters: an 8-bit address and a 16-bit read data word. Because the read word is wider than a byte, the peripheral model can fill the upper bits with random data, which tests the masking in R4. The model returns different frozen counts for the first and second freeze commands. This lets the bench tell which pass's values reach `result`, and reach a zero lower word on both passes (lower count of 1). The extreme counts 0 and 0xFFFF are applied directly, and the model's log of bus events checks the order of the freeze write and the reads.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int unsigned HALF_W = 16;

  typedef logic [HALF_W-1:0] half_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FREEZE, ST_RD0, ST_RD1, ST_RD2, ST_RD3, ST_TAIL, ST_EVAL
  } phase_t;

  // upper counter wraps at zero: elapsed = 0 - count
  function automatic half_t upper_elapsed(input half_t cnt);
    return half_t'(0) - cnt;
  endfunction

  // lower counter wraps at one: elapsed = 1 - count
  function automatic half_t lower_elapsed(input half_t cnt);
    return half_t'(1) - cnt;
  endfunction
endpackage

// File: rtl/tsr_sequencer.sv
module tsr_sequencer
  import tsr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h43,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 8'h42,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h41,
  parameter logic [7:0] FREEZE_CMD = 8'hDC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              low_is_zero,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd,
  output logic              cap_en,
  output logic [1:0]        cap_sel,
  output logic              finish
);
  phase_t phase_q;
  logic   retried_q;
  logic   retry_fire;

  assign retry_fire = (phase_q == ST_EVAL) && low_is_zero && !retried_q;
  assign finish     = (phase_q == ST_EVAL) && !retry_fire;
  assign busy       = (phase_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= ST_IDLE;
      retried_q <= 1'b0;
    end else begin
      unique case (phase_q)
        ST_IDLE:   if (start) begin
                     phase_q   <= ST_FREEZE;
                     retried_q <= 1'b0;
                   end
        ST_FREEZE: phase_q <= ST_RD0;
        ST_RD0:    phase_q <= ST_RD1;
        ST_RD1:    phase_q <= ST_RD2;
        ST_RD2:    phase_q <= ST_RD3;
        ST_RD3:    phase_q <= ST_TAIL;
        ST_TAIL:   phase_q <= ST_EVAL;
        ST_EVAL:   if (retry_fire) begin
                     retried_q <= 1'b1;
                     phase_q   <= ST_FREEZE;
                   end else begin
                     phase_q <= ST_IDLE;
                   end
        default:   phase_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_wr    = (phase_q == ST_FREEZE);
    bus_wdata = bus_wr ? FREEZE_CMD : 8'h00;
    bus_rd    = (phase_q == ST_RD0) || (phase_q == ST_RD1) ||
                (phase_q == ST_RD2) || (phase_q == ST_RD3);
    unique case (phase_q)
      ST_FREEZE:     bus_addr = CTRL_ADDR;
      ST_RD0, ST_RD1: bus_addr = HI_ADDR;
      ST_RD2, ST_RD3: bus_addr = LO_ADDR;
      default:       bus_addr = '0;
    endcase
    cap_en  = (phase_q == ST_RD1) || (phase_q == ST_RD2) ||
              (phase_q == ST_RD3) || (phase_q == ST_TAIL);
    unique case (phase_q)
      ST_RD2:  cap_sel = 2'd1;
      ST_RD3:  cap_sel = 2'd2;
      ST_TAIL: cap_sel = 2'd3;
      default: cap_sel = 2'd0;
    endcase
  end

  // R2
  freeze_write_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> (bus_addr == CTRL_ADDR && bus_wdata == FREEZE_CMD));

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  // R7
  single_retry_chk: assert property (@(posedge clk) disable iff (rst)
    retry_fire |=> (phase_q == ST_FREEZE && retried_q));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !retry_fire && phase_q != ST_EVAL) |=> (phase_q != ST_FREEZE));
endmodule

// File: rtl/tsr_assembler.sv
module tsr_assembler
  import tsr_pkg::*;
#(
  parameter int unsigned RDATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RDATA_W-1:0] rdata,
  input  logic               cap_en,
  input  logic [1:0]         cap_sel,
  input  logic               finish,
  output logic               low_is_zero,
  output logic               done,
  output logic [31:0]        result
);
  localparam int unsigned NBYTES = 4;

  logic [7:0] byte_q [NBYTES];
  half_t      hi_cnt, lo_cnt, lo_up;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        byte_q[i] <= 8'h00;
      else if (cap_en && cap_sel == 2'(i))
        byte_q[i] <= rdata[7:0];
    end
  end

  assign hi_cnt      = {byte_q[1], byte_q[0]};
  assign lo_cnt      = {byte_q[3], byte_q[2]};
  assign lo_up       = lower_elapsed(lo_cnt);
  assign low_is_zero = (lo_up == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= finish;
      if (finish)
        result <= {upper_elapsed(hi_cnt), lo_up};
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!finish && !$past(rst)) |=> $stable(result));
endmodule

// File: rtl/tmr_snapshot_reader.sv
module tmr_snapshot_reader
  import tsr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned RDATA_W   = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h43,
  parameter logic [ADDR_W-1:0] HI_ADDR   = 8'h42,
  parameter logic [ADDR_W-1:0] LO_ADDR   = 8'h41,
  parameter logic [7:0] FREEZE_CMD = 8'hDC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [31:0]        result,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [7:0]         bus_wdata,
  output logic               bus_wr,
  output logic               bus_rd,
  input  logic [RDATA_W-1:0] bus_rdata
);
  logic       cap_en, finish, low_is_zero;
  logic [1:0] cap_sel;

  tsr_sequencer #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .HI_ADDR(HI_ADDR),
    .LO_ADDR(LO_ADDR), .FREEZE_CMD(FREEZE_CMD)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .low_is_zero(low_is_zero),
    .busy(busy), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .cap_en(cap_en),
    .cap_sel(cap_sel), .finish(finish)
  );

  tsr_assembler #(.RDATA_W(RDATA_W)) u_asm (
    .clk(clk), .rst(rst), .rdata(bus_rdata), .cap_en(cap_en),
    .cap_sel(cap_sel), .finish(finish), .low_is_zero(low_is_zero),
    .done(done), .result(result)
  );

  // R8
  busy_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/tmr_snapshot_reader_tb.sv
module tmr_snapshot_reader_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done, bus_wr, bus_rd;
  logic [31:0] result;
  logic [7:0]  bus_addr, bus_wdata;
  logic [15:0] bus_rdata = '0;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  tmr_snapshot_reader u_dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .result(result), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  // peripheral model: per-freeze frozen values, byte pointer per counter
  logic [15:0] snap_hi [2];
  logic [15:0] snap_lo [2];
  logic [15:0] frz_hi = '0, frz_lo = '0;
  logic        ptr_hi = 1'b0, ptr_lo = 1'b0;
  int          n_freeze = 0;
  logic [7:0]  ev [32];
  int          ev_n = 0;

  always @(posedge clk) begin
    if (bus_wr) begin
      if (ev_n < 32) ev[ev_n] <= (bus_addr == 8'h43 && bus_wdata == 8'hDC) ? 8'h43 : 8'hFF;
      ev_n <= ev_n + 1;
      if (bus_addr == 8'h43 && bus_wdata == 8'hDC) begin
        frz_hi   <= snap_hi[n_freeze > 1 ? 1 : n_freeze];
        frz_lo   <= snap_lo[n_freeze > 1 ? 1 : n_freeze];
        ptr_hi   <= 1'b0;
        ptr_lo   <= 1'b0;
        n_freeze <= n_freeze + 1;
      end
    end
    if (bus_rd) begin
      if (ev_n < 32) ev[ev_n] <= bus_addr;
      ev_n <= ev_n + 1;
      if (bus_addr == 8'h42) begin
        bus_rdata <= {8'($urandom), ptr_hi ? frz_hi[15:8] : frz_hi[7:0]};
        ptr_hi    <= ~ptr_hi;
      end else if (bus_addr == 8'h41) begin
        bus_rdata <= {8'($urandom), ptr_lo ? frz_lo[15:8] : frz_lo[7:0]};
        ptr_lo    <= ~ptr_lo;
      end else begin
        bus_rdata <= 16'($urandom);
      end
    end else begin
      bus_rdata <= 16'($urandom);
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
      finish_run();
    end
  end

  function automatic logic [31:0] model_word(input logic [15:0] h, input logic [15:0] l);
    return {(~h) + 16'd1, (~l) + 16'd2};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  // one sample; poke_busy pulses start again while busy (R9)
  task automatic run_sample(input logic [15:0] h0, input logic [15:0] l0,
                            input logic [15:0] h1, input logic [15:0] l1,
                            input bit poke_busy);
    bit          twice;
    logic [31:0] exp;
    int          wait_n;
    snap_hi[0] = h0; snap_lo[0] = l0;
    snap_hi[1] = h1; snap_lo[1] = l1;
    @(negedge clk); n_freeze = 0; ev_n = 0;
    twice = (((~l0) + 16'd2) == 16'd0);
    exp   = twice ? model_word(h1, l1) : model_word(h0, l0);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R8 busy after start", 64'(busy), 64'd1);
    if (poke_busy) begin
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait_n = 0;
    while (done !== 1'b1 && wait_n < 40) begin
      @(negedge clk); wait_n++;
    end
    check(done === 1'b1, "R8 done seen", 64'(done), 64'd1);
    check(busy === 1'b0, "R8 busy low with done", 64'(busy), 64'd0);
    check(result[31:16] === exp[31:16], "R5 upper word", 64'(result[31:16]), 64'(exp[31:16]));
    check(result[15:0] === exp[15:0], "R6 lower word / R4 masking", 64'(result[15:0]), 64'(exp[15:0]));
    check(n_freeze == (twice ? 2 : 1), "R7 pass count", 64'(n_freeze), twice ? 64'd2 : 64'd1);
    for (int p = 0; p < (twice ? 2 : 1); p++) begin
      check(ev[p*5] === 8'h43, "R2 freeze first", 64'(ev[p*5]), 64'h43);
      check(ev[p*5+1] === 8'h42 && ev[p*5+2] === 8'h42 &&
            ev[p*5+3] === 8'h41 && ev[p*5+4] === 8'h41, "R3 read order",
            {32'(ev[p*5+1]), 8'(ev[p*5+2]), 8'(ev[p*5+3]), 8'(ev[p*5+4])}, 64'h42424141);
    end
    @(negedge clk);
    check(done === 1'b0, "R8 done one cycle", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    check(result === exp, "R10 result held", 64'(result), 64'(exp));
    check(ev_n == (twice ? 10 : 5), "R9 no extra traffic", 64'(ev_n), twice ? 64'd10 : 64'd5);
    check(busy === 1'b0, "R9 idle after run", 64'(busy), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    snap_hi[0] = '0; snap_lo[0] = '0; snap_hi[1] = '0; snap_lo[1] = '0;
    do_reset();
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && result === 32'd0, "R1 reset state",
          {30'd0, busy, done, result}, 64'd0);
    // directed corners
    run_sample(16'h1234, 16'h5678, 16'h0, 16'h0, 1'b0);
    run_sample(16'h0000, 16'h0000, 16'h0, 16'h0, 1'b0);
    run_sample(16'hFFFF, 16'hFFFF, 16'h0, 16'h0, 1'b0);
    run_sample(16'h00AA, 16'h0001, 16'h00BB, 16'h0777, 1'b0);  // R7 retry
    run_sample(16'h0101, 16'h0001, 16'h0202, 16'h0001, 1'b0);  // R7 zero again
    run_sample(16'h4321, 16'h8765, 16'h0, 16'h0, 1'b1);        // R9 start while busy
    // R11: reset mid-read, then retry still available
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    do_reset();
    check(busy === 1'b0 && done === 1'b0, "R11 idle after reset", {62'd0, busy, done}, 64'd0);
    check(result === 32'd0, "R1 result cleared by reset", 64'(result), 64'd0);
    run_sample(16'h0F0F, 16'h0001, 16'h3C3C, 16'hABCD, 1'b0);  // R11 retry after reset
    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [15:0] l0;
      l0 = ($urandom % 4 == 0) ? 16'h0001 : 16'($urandom);
      run_sample(16'($urandom), l0, 16'($urandom), 16'($urandom), ($urandom % 5) == 0);
    end
    finish_run();
  end
endmodule